// File: doc/BRIEF.md
# Audio Sample Rate Range Classifier

This block decides which speed band an incoming audio-rate reference clock belongs to. It uses a fixed 12.288 MHz system clock as its time base. The reference is brought into the system clock domain, and the number of system clock cycles between consecutive rising edges is counted. That count is compared with two thresholds: 54.8 kHz, which is 224 cycles, and 128 kHz, which is 96 cycles. The comparison sorts each measured period into single, double or quad speed.

The reported band changes only after several consecutive periods agree, so a few stray or jittery periods cannot make the output flip. Alongside the band code the block gives the oversampling multiplier that a converter clock generator would apply in that band. A valid flag shows that the band code reflects a live, confirmed measurement. The flag drops when the reference stops or the block is disabled, and the last band code is held.

Top module: `rate_band_classifier`

## Requirements
- R1: After reset the band code is 00, the valid flag is low and the multiplier output is 512.
- R2: A measured period of 224 system-clock cycles or more classifies as band code 00 (single speed) with multiplier 512.
- R3: A measured period of 97 to 223 cycles classifies as band code 01 (double speed) with multiplier 256.
- R4: A measured period of 96 cycles or less classifies as band code 10 (quad speed) with multiplier 128.
- R5: Band code 11 is never driven.
- R6: A period is the cycle count between two successive rising edges of the reference, after a two-flop synchronizer. The first edge after reset, after a timeout or after enable is raised only starts a measurement and produces no result.
- R7: The reported band changes only when 4 consecutive measurements give the same new band. A measurement of another band restarts the run, and a measurement equal to the reported band clears it.
- R8: The valid flag rises together with the first accepted classification, which also needs 4 consecutive agreeing measurements.
- R9: If no reference rising edge arrives within 4096 system-clock cycles, the valid flag drops and the band code is held. A new classification then needs a fresh edge plus 4 agreeing measurements.
- R10: While the enable is low, the valid flag is low, reference edges are ignored and the band code is held. When enable is raised again, measurement restarts from a fresh edge.
- R11: The multiplier output always matches the band code: 512 for 00, 256 for 01 and 128 for 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 12.288 MHz system clock, the measurement time base |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Audio-rate reference clock, asynchronous to clk_i |
| en_i | input | 1 | Measurement enable, active high |
| band_o | output | 2 | Speed band code: 00 single, 01 double, 10 quad |
| valid_o | output | 1 | Band code reflects a confirmed, live measurement |
| mult_o | output | 10 | Oversampling multiplier for the reported band |

## Verification
Some properties are checked on every cycle by assertions:
- band code 11 never appears;
- the band code changes only in a cycle where valid is set;
- valid falls one cycle after a timeout or a disable;
- the period counter stays at or below its limit;
- a detected edge never lasts two cycles;
- the multiplier always has exactly one bit set.

Other behaviour depends on sequences of edges, and only the directed scenarios can show it:
- the exact threshold edges at 96/97 and 223/224 cycles;
- the fact that three agreeing periods are not enough;
- the restart of a run that another band interrupts;
- recovery after a timeout or a disable, which needs a fresh arming edge.

// File: rtl/rate_band_pkg.sv
package rate_band_pkg;

    typedef enum logic [1:0] {
        BAND_SINGLE = 2'b00,
        BAND_DOUBLE = 2'b01,
        BAND_QUAD   = 2'b10
    } band_e;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], ref_i};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.sync[STAGES-1] & ~s_q.prev;

    // A detected rising edge lasts exactly one cycle (R6)
    assert_rise_isolated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int TIMEOUT = 4096,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rise_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_cnt_o,
    output logic             timeout_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             mvalid;
        logic [CNT_W-1:0] mcnt;
    } meter_state_t;

    meter_state_t m_d, m_q;

    always_comb begin
        m_d        = m_q;
        m_d.mvalid = 1'b0;
        if (!en_i) begin
            m_d.cnt   = '0;
            m_d.armed = 1'b0;
        end else if (rise_i) begin
            if (m_q.armed) begin
                m_d.mvalid = 1'b1;
                m_d.mcnt   = m_q.cnt;
            end
            m_d.cnt   = CNT_W'(1);
            m_d.armed = 1'b1;
        end else if (m_q.cnt < LIMIT) begin
            m_d.cnt = m_q.cnt + CNT_W'(1);
        end else begin
            // saturated: the running measurement is void
            m_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign meas_valid_o = m_q.mvalid;
    assign meas_cnt_o   = m_q.mcnt;
    assign timeout_o    = (m_q.cnt == LIMIT);

    // Counter never runs past its limit (R9)
    assert_cnt_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_q.cnt <= LIMIT);

    // A timeout and a finished measurement never coincide (R9)
    assert_timeout_no_meas_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> !meas_valid_o);

    // While disabled, no measurement is produced one cycle on (R10)
    assert_disabled_no_meas_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !meas_valid_o);

endmodule

// File: rtl/band_hysteresis.sv
module band_hysteresis
    import rate_band_pkg::*;
#(
    parameter int CNT_W    = 13,
    parameter int LOW_MIN  = 224,
    parameter int HIGH_MAX = 96,
    parameter int CONFIRM  = 4,
    parameter int RUN_W    = $clog2(CONFIRM + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             timeout_i,
    input  logic             meas_valid_i,
    input  logic [CNT_W-1:0] meas_cnt_i,
    output band_e            band_o,
    output logic             valid_o
);

    typedef struct packed {
        band_e            band;
        logic             valid;
        band_e            cand;
        logic [RUN_W-1:0] run;
    } hyst_state_t;

    hyst_state_t h_d, h_q;
    band_e            meas_band;
    logic [RUN_W-1:0] next_run;

    always_comb begin
        if (meas_cnt_i >= CNT_W'(LOW_MIN)) begin
            meas_band = BAND_SINGLE;
        end else if (meas_cnt_i <= CNT_W'(HIGH_MAX)) begin
            meas_band = BAND_QUAD;
        end else begin
            meas_band = BAND_DOUBLE;
        end
    end

    always_comb begin
        h_d      = h_q;
        next_run = RUN_W'(1);
        if (!en_i || timeout_i) begin
            h_d.valid = 1'b0;
            h_d.run   = '0;
        end else if (meas_valid_i) begin
            if (h_q.valid && meas_band == h_q.band) begin
                h_d.run = '0;
            end else begin
                if (h_q.run != '0 && meas_band == h_q.cand) begin
                    next_run = h_q.run + RUN_W'(1);
                end
                h_d.cand = meas_band;
                if (next_run == RUN_W'(CONFIRM)) begin
                    h_d.band  = meas_band;
                    h_d.valid = 1'b1;
                    h_d.run   = '0;
                end else begin
                    h_d.run = next_run;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            h_q <= '{band: BAND_SINGLE, valid: 1'b0, cand: BAND_SINGLE, run: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign band_o  = h_q.band;
    assign valid_o = h_q.valid;

    // Code 11 never appears (R5)
    assert_no_code3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        h_q.band != 2'b11);

    // A band change is always an accepted classification (R7)
    assert_change_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (h_q.band != $past(h_q.band)) |-> h_q.valid);

    // Valid rises only on a fresh measurement (R8)
    assert_valid_on_meas_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(h_q.valid) |-> $past(meas_valid_i));

    // Timeout clears valid (R9)
    assert_timeout_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_i |=> !h_q.valid);

    // Disable clears valid (R10)
    assert_disable_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !h_q.valid);

endmodule

// File: rtl/band_ratio_map.sv
module band_ratio_map
    import rate_band_pkg::*;
#(
    parameter int MULT_W    = 10,
    parameter int MULT_BASE = 128
) (
    input  band_e              band_i,
    output logic [MULT_W-1:0]  mult_o
);

    always_comb begin
        unique case (band_i)
            BAND_SINGLE: mult_o = MULT_W'(MULT_BASE * 4);
            BAND_DOUBLE: mult_o = MULT_W'(MULT_BASE * 2);
            BAND_QUAD:   mult_o = MULT_W'(MULT_BASE);
            default:     mult_o = MULT_W'(MULT_BASE * 4);
        endcase
    end

endmodule

// File: rtl/rate_band_classifier.sv
module rate_band_classifier
    import rate_band_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 4096,
    parameter int LOW_MIN     = 224,
    parameter int HIGH_MAX    = 96,
    parameter int CONFIRM     = 4,
    parameter int MULT_W      = 10,
    parameter int MULT_BASE   = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_i,
    input  logic              en_i,
    output logic [1:0]        band_o,
    output logic              valid_o,
    output logic [MULT_W-1:0] mult_o
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_cnt;
    logic             timeout;
    band_e            band;

    ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_i),
        .rise_o (rise)
    );

    period_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (en_i),
        .rise_i       (rise),
        .meas_valid_o (meas_valid),
        .meas_cnt_o   (meas_cnt),
        .timeout_o    (timeout)
    );

    band_hysteresis #(
        .CNT_W    (CNT_W),
        .LOW_MIN  (LOW_MIN),
        .HIGH_MAX (HIGH_MAX),
        .CONFIRM  (CONFIRM)
    ) u_hyst (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (en_i),
        .timeout_i    (timeout),
        .meas_valid_i (meas_valid),
        .meas_cnt_i   (meas_cnt),
        .band_o       (band),
        .valid_o      (valid_o)
    );

    band_ratio_map #(.MULT_W(MULT_W), .MULT_BASE(MULT_BASE)) u_map (
        .band_i (band),
        .mult_o (mult_o)
    );

    assign band_o = band;

    // Multiplier is always a single power of two (R11)
    assert_mult_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(mult_o) == 1);

endmodule

// File: tb/test_rate_band_classifier.sv
`timescale 1ns/1ps
module test_rate_band_classifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       en = 1'b1;
    logic [1:0] band;
    logic       valid;
    logic [9:0] mult;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    rate_band_classifier i_rate_band_classifier (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .ref_i   (ref_clk),
        .en_i    (en),
        .band_o  (band),
        .valid_o (valid),
        .mult_o  (mult)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    // n rising edges spaced p cycles apart; ref low at the end
    task automatic send_periods(input int n, input int p);
        for (int i = 0; i < n; i++) begin
            ref_clk = 1'b1;
            wait_cycles(p / 2);
            ref_clk = 1'b0;
            wait_cycles(p - p / 2);
        end
    endtask

    function automatic int mult_for(input int b);
        return (b == 0) ? 512 : (b == 1) ? 256 : 128;
    endfunction

    task automatic check_state(input string req, input int exp_band, input int exp_valid);
        check({req, " band"}, band, exp_band);
        check({req, " valid"}, valid, exp_valid);
        check("R11 mult", mult, mult_for(band));
        check("R5 no code 3", (band == 2'b11), 0);
    endtask

    task automatic t_reset;
        check("R1 band", band, 0);
        check("R1 valid", valid, 0);
        check("R1 mult", mult, 512);
    endtask

    task automatic t_first_accept;
        send_periods(4, 300);
        check_state("R6 first edge arms only", 0, 0);
        send_periods(1, 300);
        check_state("R8 first accept single", 0, 1);
        check("R2 mult", mult, 512);
    endtask

    task automatic t_double;
        send_periods(5, 128);
        check_state("R3 double", 1, 1);
        check("R3 mult", mult, 256);
    endtask

    task automatic t_hysteresis;
        send_periods(3, 64);
        send_periods(2, 128);
        check_state("R7 interrupted run", 1, 1);
        send_periods(5, 64);
        check_state("R7 four agree quad", 2, 1);
        check("R4 mult", mult, 128);
    endtask

    task automatic t_bounds;
        send_periods(5, 97);
        check_state("R3 boundary 97", 1, 1);
        send_periods(5, 96);
        check_state("R4 boundary 96", 2, 1);
        send_periods(5, 224);
        check_state("R2 boundary 224", 0, 1);
        send_periods(5, 223);
        check_state("R3 boundary 223", 1, 1);
    endtask

    task automatic t_timeout;
        wait_cycles(3700);
        check_state("R9 before limit", 1, 1);
        wait_cycles(600);
        check_state("R9 after limit", 1, 0);
        send_periods(4, 128);
        check_state("R9 rearm needs edge", 1, 0);
        send_periods(1, 128);
        check_state("R9 recovered", 1, 1);
    endtask

    task automatic t_enable;
        en = 1'b0;
        wait_cycles(3);
        check_state("R10 disable drops valid", 1, 0);
        send_periods(5, 64);
        check_state("R10 edges ignored", 1, 0);
        en = 1'b1;
        send_periods(5, 64);
        check_state("R10 reenabled", 2, 1);
    endtask

    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset();
        t_first_accept();
        t_double();
        t_hysteresis();
        t_bounds();
        t_timeout();
        t_enable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule